// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single receive line. It is driven by a sample-enable pulse that arrives at the bit rate times a selectable oversampling ratio. While idle it watches the line for a falling transition that follows a settled high level. It then confirms the start bit by voting on three samples near the middle of the bit and collects 8, 9 or 10 data bits in either bit order. Each data bit is a vote of three samples in the same position of its bit. After the data bits it checks one or two stop bits.

A character that ends with a good stop bit is copied into a single holding register and a full flag is raised. A read strobe lowers the full flag. If a character completes while the register is still full, that character is dropped and a sticky overrun flag is set; a separate clear strobe lowers it. A stop bit that reads low produces a one-cycle framing-error pulse and nothing is stored. Bit-rate generation is left to the surrounding logic.

Top module: `osr_uart_rx`

## Requirements
- R1: When `rxInvert` is 1 the line level is complemented before any sampling, so an idle-low line carrying complemented frames is received as the same characters.
- R2: While `rxEnable` is 0 the receiver ignores the line and sample pulses: no character is stored, no framing error is raised, and the edge history is cleared.
- R3: Data length encoding on `dataLen`: 0 selects 8 bits, 1 selects 9 bits, 2 or 3 select 10 bits. `twoStop` = 1 requires two stop bits at 1; a low second stop bit is a framing error.
- R4: With `msbFirst` = 0 the first data bit on the line lands in `rxData[0]`; with `msbFirst` = 1 the first data bit lands in bit (length-1) of `rxData`.
- R5: `rxData` bits at and above the configured data length read as 0 for a stored character.
- R6: `osrVal` sets segments per bit from 4 to 32 (values below 4 act as 4, above 32 as 32). Every bit, start bit included, is decided by the majority of the samples at segments OSR/2, OSR/2+1 and OSR/2+2, with the edge sample counted as segment 1.
- R7: A start is recognised only on a 0 sample that follows three consecutive 1 samples; two 1 samples before a 0 do not begin a frame.
- R8: If fewer than two of the three start-bit votes are 0, the receiver returns to hunting and stores nothing.
- R9: A qualifying falling edge seen before the start bit is confirmed restarts the segment count at 1.
- R10: A character whose stop bit(s) are good is loaded into `rxData` and `dataFull` rises on the clock edge that takes the last vote of the final stop bit.
- R11: If `dataFull` is 1 and `readStrobe` is 0 when a character completes, the character is discarded, `rxData` keeps its value and `overrun` is set.
- R12: `readStrobe` clears `dataFull`; when it coincides with a completion, the new character is loaded, `dataFull` stays 1 and `overrun` is not set.
- R13: `ovrClear` clears `overrun`; a new overrun in the same cycle wins.
- R14: A stop bit decided as 0 produces a one-cycle `frameErr` pulse, stores nothing and returns the receiver to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle pulse at bit rate times OSR |
| rxPin | input | 1 | Asynchronous serial line |
| rxEnable | input | 1 | Receiver enable |
| rxInvert | input | 1 | Complement the line before sampling |
| osrVal | input | 6 | Oversampling ratio, 4 to 32 |
| dataLen | input | 2 | Data length code (0:8, 1:9, 2/3:10) |
| msbFirst | input | 1 | 1 = first data bit is the most significant |
| twoStop | input | 1 | 1 = two stop bits expected |
| readStrobe | input | 1 | Consumes the held character |
| ovrClear | input | 1 | Clears the overrun flag |
| rxData | output | 10 | Held character |
| dataFull | output | 1 | Holding register full |
| overrun | output | 1 | Sticky overrun flag |
| frameErr | output | 1 | One-cycle framing-error pulse |

## Verification
The read strobe and a character completion can land on the same clock edge, and the holding register must then take the new character while keeping the full flag high and leaving overrun clear. The bench provokes this by running with a sample pulse every clock, computing from the moment it drives the start bit low the exact edge on which the final stop vote is taken (two synchronizer stages, then segment arithmetic), and raising the read strobe for that single cycle. It then judges the held data, the full flag and the overrun flag against that outcome, which differs from the read-first and load-first orderings.

// File: rtl/osr_uart_rx_pkg.sv
package osr_uart_rx_pkg;
  localparam int MAX_BITS = 10;
  localparam int POS_W    = $clog2(MAX_BITS);
  localparam int SEG_W    = 6;
  localparam int MIN_OSR  = 4;
  localparam int MAX_OSR  = 32;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_t;

  typedef struct packed {
    logic             histEn;
    logic             histClr;
    logic             frameClr;
    logic             bitWr;
    logic [POS_W-1:0] bitPos;
    logic             bitVal;
    logic             charDone;
    logic             frameBad;
  } rxStrobe_t;
endpackage

// File: rtl/osr_uart_rx_dp.sv
module osr_uart_rx_dp
  import osr_uart_rx_pkg::*;
#(
  parameter int DATA_W = MAX_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPin,
  input  logic              rxInvert,
  input  logic              readStrobe,
  input  logic              ovrClear,
  input  rxStrobe_t         strb,
  output logic              sampleBit,
  output logic              edgeSeen,
  output logic [DATA_W-1:0] rxData,
  output logic              dataFull,
  output logic              overrun,
  output logic              frameErr
);
  localparam int HIST_W = 3;

  logic              syncA, syncB;
  logic [HIST_W-1:0] hist;
  logic [DATA_W-1:0] shiftReg;
  logic              loadOk;
  logic              dropChar;

  // Two-stage synchronizer for the asynchronous line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= rxPin;
      syncB <= syncA;
    end
  end

  assign sampleBit = syncB ^ rxInvert;
  assign edgeSeen  = (hist == {HIST_W{1'b1}}) && !sampleBit;

  // History of the most recent samples, cleared at reset and while disabled
  always_ff @(posedge clk) begin
    if (!rstN || strb.histClr) begin
      hist <= '0;
    end else if (strb.histEn) begin
      hist <= {hist[HIST_W-2:0], sampleBit};
    end
  end

  // Assembly register: bits written by position, cleared when a frame begins
  always_ff @(posedge clk) begin
    if (!rstN || strb.frameClr) begin
      shiftReg <= '0;
    end else if (strb.bitWr) begin
      shiftReg[strb.bitPos] <= strb.bitVal;
    end
  end

  assign loadOk   = strb.charDone && (!dataFull || readStrobe);
  assign dropChar = strb.charDone && dataFull && !readStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData   <= '0;
      dataFull <= 1'b0;
    end else if (loadOk) begin
      rxData   <= shiftReg;
      dataFull <= 1'b1;
    end else if (readStrobe) begin
      dataFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrun <= 1'b0;
    end else if (dropChar) begin
      overrun <= 1'b1;
    end else if (ovrClear) begin
      overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) frameErr <= 1'b0;
    else       frameErr <= strb.frameBad;
  end
endmodule

// File: rtl/osr_uart_rx_ctl.sv
module osr_uart_rx_ctl
  import osr_uart_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxEnable,
  input  logic [SEG_W-1:0] osrVal,
  input  logic [1:0]       dataLen,
  input  logic             msbFirst,
  input  logic             twoStop,
  input  logic             sampleBit,
  input  logic             edgeSeen,
  output rxStrobe_t        strb
);
  localparam logic [SEG_W-1:0] OSR_LO = SEG_W'(MIN_OSR);
  localparam logic [SEG_W-1:0] OSR_HI = SEG_W'(MAX_OSR);
  localparam logic [SEG_W-1:0] SEG_ONE = SEG_W'(1);

  rxState_t         state;
  logic [SEG_W-1:0] segCnt;
  logic [POS_W-1:0] bitIdx;
  logic             stopIdx;
  logic [1:0]       vote;

  logic [SEG_W-1:0] osrEff, halfSeg, segNow;
  logic [POS_W-1:0] lastIdx;
  logic [1:0]       oneCount;
  logic             active, restart, decide, bitOne;

  always_comb begin
    if (osrVal < OSR_LO)      osrEff = OSR_LO;
    else if (osrVal > OSR_HI) osrEff = OSR_HI;
    else                      osrEff = osrVal;
  end

  assign halfSeg = osrEff >> 1;

  always_comb begin
    case (dataLen)
      2'd0:    lastIdx = POS_W'(7);
      2'd1:    lastIdx = POS_W'(8);
      default: lastIdx = POS_W'(9);
    endcase
  end

  assign segNow   = (segCnt >= osrEff) ? SEG_ONE : segCnt + SEG_ONE;
  assign active   = rxEnable && sampleTick;
  assign restart  = (state == ST_START) && edgeSeen;
  assign decide   = active && (state != ST_HUNT) && !restart
                    && (segNow == halfSeg + SEG_W'(2));
  assign oneCount = {1'b0, vote[0]} + {1'b0, vote[1]} + {1'b0, sampleBit};
  assign bitOne   = oneCount >= 2'd2;

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      state   <= ST_HUNT;
      segCnt  <= SEG_ONE;
      bitIdx  <= '0;
      stopIdx <= 1'b0;
      vote    <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_HUNT: begin
          if (edgeSeen) begin
            state  <= ST_START;
            segCnt <= SEG_ONE;
          end
        end
        default: begin
          if (restart) begin
            segCnt <= SEG_ONE;
          end else begin
            segCnt <= segNow;
            if (segNow == halfSeg)                vote[0] <= sampleBit;
            if (segNow == halfSeg + SEG_ONE)      vote[1] <= sampleBit;
            if (decide) begin
              case (state)
                ST_START: begin
                  state  <= bitOne ? ST_HUNT : ST_DATA;
                  bitIdx <= '0;
                end
                ST_DATA: begin
                  if (bitIdx == lastIdx) begin
                    state   <= ST_STOP;
                    stopIdx <= 1'b0;
                  end else begin
                    bitIdx <= bitIdx + POS_W'(1);
                  end
                end
                default: begin
                  if (bitOne && twoStop && !stopIdx) stopIdx <= 1'b1;
                  else                               state   <= ST_HUNT;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.histEn   = active;
    strb.histClr  = !rxEnable;
    strb.frameClr = active && (state == ST_HUNT) && edgeSeen;
    strb.bitWr    = decide && (state == ST_DATA);
    strb.bitPos   = msbFirst ? (lastIdx - bitIdx) : bitIdx;
    strb.bitVal   = bitOne;
    strb.charDone = decide && (state == ST_STOP) && bitOne && (!twoStop || stopIdx);
    strb.frameBad = decide && (state == ST_STOP) && !bitOne;
  end
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osr_uart_rx_pkg::*;
#(
  parameter int DATA_W = MAX_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxPin,
  input  logic              rxEnable,
  input  logic              rxInvert,
  input  logic [SEG_W-1:0]  osrVal,
  input  logic [1:0]        dataLen,
  input  logic              msbFirst,
  input  logic              twoStop,
  input  logic              readStrobe,
  input  logic              ovrClear,
  output logic [DATA_W-1:0] rxData,
  output logic              dataFull,
  output logic              overrun,
  output logic              frameErr
);
  rxStrobe_t ctlStrb;
  logic      sampleBit;
  logic      edgeSeen;
  logic      charDone;

  assign charDone = ctlStrb.charDone;

  osr_uart_rx_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .rxEnable   (rxEnable),
    .osrVal     (osrVal),
    .dataLen    (dataLen),
    .msbFirst   (msbFirst),
    .twoStop    (twoStop),
    .sampleBit  (sampleBit),
    .edgeSeen   (edgeSeen),
    .strb       (ctlStrb)
  );

  osr_uart_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxPin      (rxPin),
    .rxInvert   (rxInvert),
    .readStrobe (readStrobe),
    .ovrClear   (ovrClear),
    .strb       (ctlStrb),
    .sampleBit  (sampleBit),
    .edgeSeen   (edgeSeen),
    .rxData     (rxData),
    .dataFull   (dataFull),
    .overrun    (overrun),
    .frameErr   (frameErr)
  );
endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              readStrobe,
  input logic              ovrClear,
  input logic [1:0]        dataLen,
  input logic              charDone,
  input logic [DATA_W-1:0] rxData,
  input logic              dataFull,
  input logic              overrun,
  input logic              frameErr
);
  p_done_sets_full_r10: assert property (@(posedge clk) disable iff (!rstN)
    charDone |=> dataFull);

  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dataFull && !readStrobe) |=> $stable(rxData));

  p_ovr_needs_full_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(dataFull));

  p_read_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !charDone) |=> !dataFull);

  p_ovr_clear_r13: assert property (@(posedge clk) disable iff (!rstN)
    (ovrClear && !(charDone && dataFull && !readStrobe)) |=> !overrun);

  p_err_pulse_r14: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !frameErr);

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dataFull) && ($past(dataLen) == 2'd0)) |-> (rxData[DATA_W-1:8] == '0));
endmodule

bind osr_uart_rx osr_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxEnable   (rxEnable),
  .readStrobe (readStrobe),
  .ovrClear   (ovrClear),
  .dataLen    (dataLen),
  .charDone   (charDone),
  .rxData     (rxData),
  .dataFull   (dataFull),
  .overrun    (overrun),
  .frameErr   (frameErr)
);

// File: tb/osr_uart_rx_tb.sv
module osr_uart_rx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b0;
  logic       rxEnable = 1'b1;
  logic       rxInvert = 1'b0;
  logic [5:0] osrVal = 6'd8;
  logic [1:0] dataLen = 2'd0;
  logic       msbFirst = 1'b0;
  logic       twoStop = 1'b0;
  logic       manualRead = 1'b0;
  logic       autoPulse = 1'b0;
  logic       ovrClear = 1'b0;
  logic       readStrobe;
  logic [9:0] rxData;
  logic       dataFull, overrun, frameErr;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  int  tickDiv = 1;
  int  tickCnt = 0;
  int  osrCur = 8;
  int  errCount = 0;
  int  lastStartCyc = 0;
  bit  startMark = 0;
  bit  autoRead = 1;
  bit  doneFlag = 0;
  logic prevFull = 1'b0;
  logic [9:0] expQ[$];

  assign readStrobe = manualRead | autoPulse;

  always #10 clk = ~clk;

  osr_uart_rx u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxPin(rxLine),
    .rxEnable(rxEnable), .rxInvert(rxInvert), .osrVal(osrVal),
    .dataLen(dataLen), .msbFirst(msbFirst), .twoStop(twoStop),
    .readStrobe(readStrobe), .ovrClear(ovrClear), .rxData(rxData),
    .dataFull(dataFull), .overrun(overrun), .frameErr(frameErr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tickCnt >= tickDiv - 1) begin
      tickCnt    <= 0;
      sampleTick <= 1'b1;
    end else begin
      tickCnt    <= tickCnt + 1;
      sampleTick <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Monitor: scoreboard pop on every rising full flag, and frame error counting
  always @(negedge clk) begin
    autoPulse <= 1'b0;
    if (frameErr) errCount <= errCount + 1;
    if (rstN && dataFull && !prevFull) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected char", {22'd0, rxData}, 32'd0);
      end else begin
        logic [9:0] e;
        e = expQ.pop_front();
        check(rxData == e, "R10 scoreboard data", {22'd0, rxData}, {22'd0, e});
      end
      if (autoRead) autoPulse <= 1'b1;
    end
    prevFull <= dataFull;
  end

  task automatic waitTicks(input int n);
    for (int k = 0; k < n; k++) begin
      do @(posedge clk); while (sampleTick !== 1'b1);
    end
    @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input int n);
    rxLine = b ^ rxInvert;
    waitTicks(n);
  endtask

  task automatic idle(input int bits);
    sendBit(1'b1, bits * osrCur);
  endtask

  // Driver: pushes the expected character, then drives the frame
  task automatic sendFrame(input logic [9:0] val, input int len, input bit msb,
                           input bit two, input logic stop1, input logic stop2,
                           input bit expectIt);
    logic [9:0] masked;
    masked = val & ((10'd1 << len) - 10'd1);
    dataLen  = (len == 8) ? 2'd0 : (len == 9) ? 2'd1 : 2'd2;
    msbFirst = msb;
    twoStop  = two;
    if (expectIt) expQ.push_back(masked);
    idle(3);
    lastStartCyc = cyc;
    startMark = 1;
    sendBit(1'b0, osrCur);
    for (int i = 0; i < len; i++)
      sendBit(msb ? masked[len-1-i] : masked[i], osrCur);
    sendBit(stop1, osrCur);
    if (two) sendBit(stop2, osrCur);
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int errBefore;
    rxLine = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(!dataFull && !overrun && !frameErr && rxData == 10'd0, "R10 reset",
          {dataFull, overrun, frameErr}, 32'd0);

    // R7: line held low, two high samples then low must not open a frame
    errBefore = errCount;
    sendBit(1'b0, 3 * osrCur);
    sendBit(1'b1, 2);
    sendBit(1'b0, 12 * osrCur);
    check(!dataFull && errCount == errBefore, "R7 two ones no start",
          {dataFull, 8'(errCount - errBefore)}, 32'd0);

    // R6 R4 plain 8-bit lsb-first frames
    sendFrame(10'h0A5, 8, 0, 0, 1, 1, 1);
    sendFrame(10'h03C, 8, 0, 0, 1, 1, 1);
    // R4 msb-first, R3 nine and ten bits, R5 upper bits zero
    sendFrame(10'h0B1, 8, 1, 0, 1, 1, 1);
    sendFrame(10'h1C3, 9, 1, 0, 1, 1, 1);
    check(rxData[9] == 1'b0, "R5 upper bit zero len9", {31'd0, rxData[9]}, 32'd0);
    sendFrame(10'h2D7, 10, 0, 0, 1, 1, 1);
    sendFrame(10'h301, 10, 1, 1, 1, 1, 1);
    check(expQ.size() == 0, "R3 all frames seen", expQ.size(), 32'd0);

    // R14 bad stop bit, R3 bad second stop bit
    errBefore = errCount;
    sendFrame(10'h055, 8, 0, 0, 0, 1, 0);
    check(errCount == errBefore + 1 && !dataFull, "R14 framing pulse",
          errCount - errBefore, 32'd1);
    errBefore = errCount;
    sendFrame(10'h0AA, 8, 0, 1, 1, 0, 0);
    check(errCount == errBefore + 1 && !dataFull, "R3 second stop low",
          errCount - errBefore, 32'd1);

    // R8 short glitch rejected
    errBefore = errCount;
    idle(3);
    sendBit(1'b0, 2);
    sendBit(1'b1, 12 * osrCur);
    check(!dataFull && errCount == errBefore, "R8 glitch rejected",
          {dataFull, 8'(errCount - errBefore)}, 32'd0);

    // R9 restart: a one-sample dip, ones, then the real start
    idle(3);
    sendBit(1'b0, 1);
    sendBit(1'b1, 4);
    expQ.push_back(10'h096);
    startMark = 1;
    sendBit(1'b0, osrCur);
    for (int i = 0; i < 8; i++) sendBit(10'h096 >> i, osrCur);
    sendBit(1'b1, osrCur);
    idle(2);
    check(expQ.size() == 0, "R9 restart frame received", expQ.size(), 32'd0);

    // R1 inverted line
    rxInvert = 1'b1;
    sendFrame(10'h0E4, 8, 0, 0, 1, 1, 1);
    rxInvert = 1'b0;
    check(expQ.size() == 0, "R1 inverted frame", expQ.size(), 32'd0);

    // R6 ratio 4 with a pulse every other clock, and ratio 32
    tickDiv = 2; osrCur = 4; osrVal = 6'd4;
    sendFrame(10'h05A, 8, 0, 0, 1, 1, 1);
    tickDiv = 1; osrCur = 32; osrVal = 6'd32;
    sendFrame(10'h3A5, 10, 0, 0, 1, 1, 1);
    check(expQ.size() == 0, "R6 ratios 4 and 32", expQ.size(), 32'd0);
    osrCur = 8; osrVal = 6'd8;

    // R2 disabled receiver ignores a frame
    rxEnable = 1'b0;
    errBefore = errCount;
    sendFrame(10'h0F0, 8, 0, 0, 1, 1, 0);
    check(!dataFull && errCount == errBefore, "R2 disabled ignores", {31'd0, dataFull}, 32'd0);
    rxEnable = 1'b1;

    // R11 overrun keeps the first character
    autoRead = 0;
    sendFrame(10'h011, 8, 0, 0, 1, 1, 1);
    sendFrame(10'h022, 8, 0, 0, 1, 1, 0);
    check(overrun && dataFull, "R11 overrun set", {overrun, dataFull}, 32'd3);
    check(rxData == 10'h011, "R11 data kept", {22'd0, rxData}, 32'h011);
    // R13 clear strobe
    ovrClear = 1'b1; @(negedge clk); ovrClear = 1'b0; @(negedge clk);
    check(!overrun, "R13 overrun cleared", {31'd0, overrun}, 32'd0);
    // R12 read clears full
    manualRead = 1'b1; @(negedge clk); manualRead = 1'b0; @(negedge clk);
    check(!dataFull, "R12 read clears", {31'd0, dataFull}, 32'd0);

    // R12 read on the completion edge: held A, then B completes under a read
    sendFrame(10'h033, 8, 0, 0, 1, 1, 1);
    startMark = 0;
    fork
      sendFrame(10'h0C6, 8, 0, 0, 1, 1, 0);
      begin
        int target;
        wait (startMark);
        // edge sample at +3, final stop vote at segment OSR/2+2 of bit 9
        target = lastStartCyc + 3 + 9 * osrCur + osrCur / 2 + 1;
        while (cyc < target - 1) @(negedge clk);
        manualRead = 1'b1;
        @(negedge clk);
        manualRead = 1'b0;
      end
    join
    check(dataFull && !overrun, "R12 collision flags", {dataFull, overrun}, 32'd2);
    check(rxData == 10'h0C6, "R12 collision data", {22'd0, rxData}, 32'h0C6);
    manualRead = 1'b1; @(negedge clk); manualRead = 1'b0; @(negedge clk);

    // R10 final scoreboard drain
    check(expQ.size() == 0, "R10 queue empty", expQ.size(), 32'd0);

    doneFlag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule